// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This block is the datapath of a direct digital synthesizer. A 28-bit phase accumulator grows by a tuning word on every clock, so the output frequency is the tuning word times the clock frequency divided by 2^28. Two tuning words and two 12-bit phase offsets are held outside the block. Two select inputs pick which tuning word drives the accumulator and which offset is added to its value. The offset is placed in the top 12 bits of the phase, so an offset of 4096 would be one full turn.

The offset phase is shaped into an unsigned 10-bit sample with midscale 512. The shape is a sine read from a quarter-wave table that is built at elaboration, a triangle folded from the phase, or a square taken from the phase MSB at full or half rate. Three control inputs act on the oscillator. One parks it at phase zero and midscale. One freezes it in place. One switches the output off.

Top module: `dds_nco_core`

## Requirements
- R1: On each clock where neither park nor freeze is active, the accumulator advances by `tune_word1` when `freq_sel` is 1 and by `tune_word0` when it is 0, modulo 2^28.
- R2: The offset (`phase_ofs1` when `phase_sel` is 1, else `phase_ofs0`) is added to the accumulator as bits 27..16 of the phase, so the offset value 1024 shifts the waveform by a quarter cycle.
- R3: In sine mode (`ctl_bitout`=0, `ctl_tri`=0), the sample is within 3 LSB of 511.5 + 511·sin(2π(a+0.5)/1024), where a is bits 27..18 of the offset phase.
- R4: In triangle mode (`ctl_bitout`=0, `ctl_tri`=1), with t = bits 27..17 of the offset phase, the sample is t[9:0] when t[10] is 0 and 1023 − t[9:0] when t[10] is 1.
- R5: In full-rate square mode (`ctl_bitout`=1, `ctl_div2`=1), the sample is 1023 while phase bit 27 is 0 and 0 while it is 1.
- R6: In half-rate square mode (`ctl_bitout`=1, `ctl_div2`=0), an internal flag is cleared by park and toggles on every update in which phase bit 27 goes from 0 to 1 relative to the previous update. The sample is 1023 while the flag is 1 and 0 otherwise.
- R7: While `ctl_reset` is 1, the accumulator is zero and the sample is 512. Accumulation resumes from zero on the first clock after `ctl_reset` returns to 0.
- R8: While `ctl_hold` is 1 (and `ctl_pwrdn` is 0), the accumulator, the half-rate flag and the sample keep their values.
- R9: While `ctl_pwrdn` is 1, the sample is 512 and `out_en` is 0. The accumulator keeps running, so the waveform continues at the phase it would have reached.
- R10: The sample reflects the phase and controls present at the previous clock edge, which is one register of latency. `out_en` follows `ctl_pwrdn` with the same latency.
- R11: `ctl_bitout` takes priority over `ctl_tri`.
- R12: While `rst_n` is 0, the sample is 512, `out_en` is 0 and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tune_word0 | input | 28 | Tuning word 0 |
| tune_word1 | input | 28 | Tuning word 1 |
| phase_ofs0 | input | 12 | Phase offset 0 |
| phase_ofs1 | input | 12 | Phase offset 1 |
| freq_sel | input | 1 | Tuning word select |
| phase_sel | input | 1 | Phase offset select |
| ctl_reset | input | 1 | Park at phase zero and midscale |
| ctl_hold | input | 1 | Freeze accumulator and sample |
| ctl_pwrdn | input | 1 | Switch the output off |
| ctl_bitout | input | 1 | Square output from the phase MSB |
| ctl_div2 | input | 1 | Square at full rate (1) or half rate (0) |
| ctl_tri | input | 1 | Triangle instead of sine |
| sample_out | output | 10 | Unsigned sample, midscale 512 |
| out_en | output | 1 | Output active |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. The accumulator step, the offset, the waveform and the power-down flag all pass through one output register. The bench changes inputs only at falling edges. Before each rising edge it works out the sample that edge must produce, using its own model of the accumulator. It then reads the outputs at the next falling edge, so each check lines up with the edge that caused it. Freeze checks compare against the value read just before that edge. Power-down release checks confirm that the phase kept advancing while the output was off.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE    = 2'd0,
    WAVE_TRI     = 2'd1,
    WAVE_SQ_FULL = 2'd2,
    WAVE_SQ_HALF = 2'd3
  } wave_t;

  // Bit output beats triangle; triangle beats sine.
  function automatic wave_t pick_wave(input logic bitout, input logic div2,
                                      input logic tri_sel);
    if (bitout) return div2 ? WAVE_SQ_FULL : WAVE_SQ_HALF;
    if (tri_sel) return WAVE_TRI;
    return WAVE_SINE;
  endfunction

  // Rational sine approximation sampled at bin centres of one quarter wave.
  // With p = half-cycle in units and u the centre point:
  // sin ~ 4u(p-u) / (1.25 p^2 - u(p-u)).
  function automatic longint quarter_mag(input longint idx, input longint n,
                                         input longint amp);
    longint u, p, q, num, den;
    u   = 2 * idx + 1;
    p   = 4 * n;
    q   = u * (p - u);
    num = 4 * q * amp;
    den = (5 * p * p) / 4 - q;
    return num / den;
  endfunction

endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int ACC_W   = 28,
  parameter int PHASE_W = 12,
  parameter int TOP_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               advance,
  input  logic               freq_sel,
  input  logic [ACC_W-1:0]   word0,
  input  logic [ACC_W-1:0]   word1,
  input  logic               phase_sel,
  input  logic [PHASE_W-1:0] ofs0,
  input  logic [PHASE_W-1:0] ofs1,
  output logic [TOP_W-1:0]   ph_top
);
  localparam int PAD_W = ACC_W - PHASE_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step_word;
  logic [ACC_W-1:0] ofs_aligned;
  logic [ACC_W-1:0] phase_sum;

  assign step_word   = freq_sel ? word1 : word0;
  assign ofs_aligned = {(phase_sel ? ofs1 : ofs0), {PAD_W{1'b0}}};
  assign phase_sum   = acc_q + ofs_aligned;
  assign ph_top      = phase_sum[ACC_W-1 -: TOP_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear)   acc_q <= '0;
    else if (advance) acc_q <= acc_q + step_word;
  end

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && advance) |=> acc_q == $past(acc_q) + $past(freq_sel ? word1 : word0)); // R1
  AST_OFS_LOW_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    phase_sum[PAD_W-1:0] == acc_q[PAD_W-1:0]); // R2
  AST_ACC_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc_q == '0); // R7
  AST_ACC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(acc_q)); // R8
endmodule

// File: rtl/nco_quarter_sine.sv
module nco_quarter_sine #(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 9
) (
  input  logic [ADDR_W-1:0] idx,
  output logic [MAG_W-1:0]  mag
);
  localparam int  QN  = 2 ** ADDR_W;
  localparam longint AMP = (2 ** MAG_W) - 1;

  logic [MAG_W-1:0] table_q [QN];

  for (genvar gi = 0; gi < QN; gi++) begin : g_entry
    assign table_q[gi] = MAG_W'(nco_pkg::quarter_mag(longint'(gi), longint'(QN), AMP));
  end

  assign mag = table_q[idx];
endmodule

// File: rtl/nco_wave_shaper.sv
module nco_wave_shaper #(
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [OUT_W:0]   ph_top,
  input  logic             bitout,
  input  logic             div2,
  input  logic             tri_sel,
  output logic [OUT_W-1:0] shaped
);
  import nco_pkg::*;

  localparam int QA_W = OUT_W - 2;
  localparam int MID  = 2 ** (OUT_W - 1);

  logic [OUT_W-1:0] addr;
  logic [QA_W-1:0]  qidx;
  logic [OUT_W-2:0] mag;
  logic [OUT_W-1:0] sine_val;
  logic [OUT_W-1:0] tri_val;
  logic             ph_msb;
  logic             msb_q;
  logic             div_q;
  logic             msb_rise;
  logic             half_next;
  wave_t            wave;

  assign addr = ph_top[OUT_W:1];
  assign qidx = addr[OUT_W-2] ? ~addr[QA_W-1:0] : addr[QA_W-1:0];

  nco_quarter_sine #(.ADDR_W(QA_W), .MAG_W(OUT_W-1)) u_rom (
    .idx(qidx),
    .mag(mag)
  );

  assign sine_val = addr[OUT_W-1] ? (OUT_W'(MID - 1) - {1'b0, mag})
                                  : (OUT_W'(MID) + {1'b0, mag});
  assign tri_val  = ph_top[OUT_W] ? ~ph_top[OUT_W-1:0] : ph_top[OUT_W-1:0];

  assign ph_msb    = ph_top[OUT_W];
  assign msb_rise  = ph_msb & ~msb_q;
  assign half_next = div_q ^ msb_rise;
  assign wave      = pick_wave(bitout, div2, tri_sel);

  always_comb begin
    unique case (wave)
      WAVE_SINE:    shaped = sine_val;
      WAVE_TRI:     shaped = tri_val;
      WAVE_SQ_FULL: shaped = ph_msb ? '0 : '1;
      WAVE_SQ_HALF: shaped = half_next ? '1 : '0;
      default:      shaped = sine_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      msb_q <= 1'b0;
      div_q <= 1'b0;
    end else if (advance) begin
      msb_q <= ph_msb;
      div_q <= half_next;
    end
  end

  AST_SQUARE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    bitout |-> (shaped == '0 || shaped == '1)); // R5
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && msb_rise) |=> div_q != $past(div_q)); // R6
  AST_HALF_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !div_q && !msb_q); // R6
endmodule

// File: rtl/dds_nco_core.sv
module dds_nco_core #(
  parameter int ACC_W   = 28,
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   tune_word0,
  input  logic [ACC_W-1:0]   tune_word1,
  input  logic [PHASE_W-1:0] phase_ofs0,
  input  logic [PHASE_W-1:0] phase_ofs1,
  input  logic               freq_sel,
  input  logic               phase_sel,
  input  logic               ctl_reset,
  input  logic               ctl_hold,
  input  logic               ctl_pwrdn,
  input  logic               ctl_bitout,
  input  logic               ctl_div2,
  input  logic               ctl_tri,
  output logic [OUT_W-1:0]   sample_out,
  output logic               out_en
);
  localparam int TOP_W = OUT_W + 1;
  localparam logic [OUT_W-1:0] MIDSCALE = OUT_W'(2 ** (OUT_W - 1));

  logic [TOP_W-1:0] ph_top;
  logic [OUT_W-1:0] shaped;
  logic             run_en;

  assign run_en = ~ctl_hold;

  nco_phase_accum #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .TOP_W(TOP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(ctl_reset), .advance(run_en),
    .freq_sel(freq_sel), .word0(tune_word0), .word1(tune_word1),
    .phase_sel(phase_sel), .ofs0(phase_ofs0), .ofs1(phase_ofs1),
    .ph_top(ph_top)
  );

  nco_wave_shaper #(.OUT_W(OUT_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .clear(ctl_reset), .advance(run_en),
    .ph_top(ph_top), .bitout(ctl_bitout), .div2(ctl_div2), .tri_sel(ctl_tri),
    .shaped(shaped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_out <= MIDSCALE;
      out_en     <= 1'b0;
    end else begin
      out_en <= ~ctl_pwrdn;
      if (ctl_reset || ctl_pwrdn) sample_out <= MIDSCALE;
      else if (!ctl_hold)         sample_out <= shaped;
    end
  end

  AST_PARK_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> sample_out == MIDSCALE); // R7
  AST_OFF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pwrdn |=> (!out_en && sample_out == MIDSCALE)); // R9
  AST_ON_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_pwrdn |=> out_en); // R10
  AST_FREEZE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hold && !ctl_reset && !ctl_pwrdn) |=> $stable(sample_out)); // R8
endmodule

// File: tb/dds_nco_core_tb.sv
module dds_nco_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] w0, w1;
  logic [11:0] o0, o1;
  logic        fsel, psel, c_reset, c_hold, c_pwrdn, c_bitout, c_div2, c_tri;
  logic [9:0]  sample_out;
  logic        out_en;

  int n_checks = 0;
  int n_errs   = 0;

  logic [27:0] m_acc;
  logic        m_msb, m_div;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_nco_core u_dut (
    .clk(clk), .rst_n(rst_n), .tune_word0(w0), .tune_word1(w1),
    .phase_ofs0(o0), .phase_ofs1(o1), .freq_sel(fsel), .phase_sel(psel),
    .ctl_reset(c_reset), .ctl_hold(c_hold), .ctl_pwrdn(c_pwrdn),
    .ctl_bitout(c_bitout), .ctl_div2(c_div2), .ctl_tri(c_tri),
    .sample_out(sample_out), .out_en(out_en)
  );

  task automatic chk(input string req, input string what, input int got,
                     input int exp, input int tol);
    int d;
    n_checks++;
    d = got - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, got, exp, tol);
    end
  endtask

  function automatic int sine_ref(input logic [27:0] s);
    real th;
    th = 2.0 * PI * (real'(s[27:18]) + 0.5) / 1024.0;
    return int'(511.5 + 511.0 * $sin(th));
  endfunction

  // One clock: predict the edge result, clock it, read at the falling edge.
  task automatic tick(input string req);
    logic [27:0] word, sum;
    logic [10:0] t;
    logic        msb, rise, hnext;
    int exp_s, tol, exp_en;
    word = fsel ? w1 : w0;
    sum  = m_acc + {(psel ? o1 : o0), 16'h0};
    tol  = 0;
    exp_en = c_pwrdn ? 0 : 1;
    if (c_reset) begin
      exp_s = 512;
      m_acc = '0; m_msb = 1'b0; m_div = 1'b0;
    end else begin
      msb   = sum[27];
      rise  = msb && !m_msb;
      hnext = m_div ^ rise;
      t     = sum[27:17];
      if (c_pwrdn)       exp_s = 512;
      else if (c_hold)   exp_s = int'(sample_out);
      else if (c_bitout) exp_s = c_div2 ? (msb ? 0 : 1023) : (hnext ? 1023 : 0);
      else if (c_tri)    exp_s = t[10] ? 1023 - int'(t[9:0]) : int'(t[9:0]);
      else begin
        exp_s = sine_ref(sum);
        tol = 3;
      end
      if (!c_hold) begin
        m_acc = m_acc + word; m_msb = msb; m_div = hnext;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "sample", int'(sample_out), exp_s, tol);
    chk(req, "out_en", int'(out_en), exp_en, 0);
  endtask

  task automatic ticks(input string req, input int n);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic set_mode(input logic b, input logic d, input logic t);
    c_bitout = b; c_div2 = d; c_tri = t;
  endtask

  task automatic park;
    c_reset = 1'b1; tick("R7"); c_reset = 1'b0;
  endtask

  task automatic t_reset_state;  // R12
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "sample", int'(sample_out), 512, 0);
    chk("R12", "out_en", int'(out_en), 0, 0);
    rst_n = 1'b1;
    m_acc = '0; m_msb = 1'b0; m_div = 1'b0;
  endtask

  task automatic t_latency;  // R10: first edge after park shows offset only
    set_mode(1'b0, 1'b0, 1'b1);
    w0 = 28'h0800000; o0 = 12'd0; psel = 1'b0; fsel = 1'b0;
    park;
    tick("R10");
    ticks("R10", 3);
  endtask

  task automatic t_sine;  // R3
    set_mode(1'b0, 1'b0, 1'b0);
    w0 = 28'd4194304; fsel = 1'b0;
    park;
    ticks("R3", 70);
    w0 = 28'd1234567;
    ticks("R3", 60);
  endtask

  task automatic t_fsel;  // R1
    set_mode(1'b0, 1'b0, 1'b1);
    w0 = 28'd0; w1 = 28'd3000017;
    fsel = 1'b1;
    park;
    ticks("R1", 25);
    fsel = 1'b0;
    ticks("R1", 5);
    w0 = 28'hFFFFFFF;
    ticks("R1", 10);
  endtask

  task automatic t_phase;  // R2
    set_mode(1'b0, 1'b0, 1'b1);
    w0 = 28'd0; fsel = 1'b0;
    o0 = 12'd0; o1 = 12'd1024; psel = 1'b1;
    park;
    tick("R2");
    chk("R2", "quarter offset", int'(sample_out), 512, 0);
    o1 = 12'd3072;
    tick("R2");
    chk("R2", "three-quarter offset", int'(sample_out), 511, 0);
    psel = 1'b0;
    tick("R2");
    chk("R2", "offset 0 selected", int'(sample_out), 0, 0);
    psel = 1'b1; o1 = 12'd4095;
    w0 = 28'd2000003;
    ticks("R2", 20);
    psel = 1'b0;
  endtask

  task automatic t_triangle;  // R4
    set_mode(1'b0, 1'b0, 1'b1);
    w0 = 28'd9000011; o0 = 12'd300;
    park;
    ticks("R4", 40);
  endtask

  task automatic t_square_full;  // R5
    set_mode(1'b1, 1'b1, 1'b0);
    w0 = 28'd16777216; o0 = 12'd0;
    park;
    ticks("R5", 40);
  endtask

  task automatic t_square_half;  // R6
    set_mode(1'b1, 1'b0, 1'b0);
    w0 = 28'd16777216;
    park;
    ticks("R6", 70);
  endtask

  task automatic t_reset_ctl;  // R7
    set_mode(1'b0, 1'b0, 1'b0);
    w0 = 28'd5000000;
    ticks("R7", 10);
    c_reset = 1'b1;
    ticks("R7", 3);
    c_reset = 1'b0;
    ticks("R7", 10);
  endtask

  task automatic t_hold;  // R8
    set_mode(1'b1, 1'b0, 1'b0);
    w0 = 28'd33554432;
    park;
    ticks("R8", 6);
    c_hold = 1'b1;
    ticks("R8", 8);
    c_hold = 1'b0;
    ticks("R8", 12);
    set_mode(1'b0, 1'b0, 1'b0);
    c_hold = 1'b1;
    ticks("R8", 4);
    c_hold = 1'b0;
    ticks("R8", 6);
  endtask

  task automatic t_pwrdn;  // R9
    set_mode(1'b0, 1'b0, 1'b1);
    w0 = 28'd7000001;
    ticks("R9", 4);
    c_pwrdn = 1'b1;
    ticks("R9", 9);
    c_pwrdn = 1'b0;
    ticks("R9", 8);
  endtask

  task automatic t_priority;  // R11
    set_mode(1'b1, 1'b1, 1'b1);
    w0 = 28'd16777216;
    park;
    ticks("R11", 20);
  endtask

  initial begin
    rst_n = 1'b0;
    w0 = '0; w1 = '0; o0 = '0; o1 = '0;
    fsel = 1'b0; psel = 1'b0;
    c_reset = 1'b0; c_hold = 1'b0; c_pwrdn = 1'b0;
    c_bitout = 1'b0; c_div2 = 1'b0; c_tri = 1'b0;
    m_acc = '0; m_msb = 1'b0; m_div = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_sine();
    t_fsel();
    t_phase();
    t_triangle();
    t_square_full();
    t_square_half();
    t_reset_ctl();
    t_hold();
    t_pwrdn();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule